// File: doc/BRIEF.md
# Instruction Address Translation Probe

This block looks up an instruction fetch address in a set-associative translation table and returns the matching physical address. It has no side effects. It never raises an exception and never changes table state. When the result is not usable it returns zero and a clear status flag. A caller such as a debug path or a prefetch filter presents a virtual address together with three control bits:

- a translation-enable bit,
- a supervisor-mode bit,
- a flag saying the translation unit is present.

One cycle later the block answers with a result strobe, an ok flag and the physical address.

The table has `NWAYS` ways and `2**SET_W` sets. Each entry holds two parts:

- a match word, carrying a virtual tag and a valid bit;
- a translate word, carrying a physical page number and two execute-permission bits, one for supervisor mode and one for user mode.

Entries are loaded through a single write port that names a way and a set. A synchronous reset invalidates every entry.

With the default parameters the page is 8 KB (13 offset bits), there are 64 sets (6 index bits) and addresses are 32 bits wide.

Top module: `itlb_probe`

## Requirements
- R1: When `xlate_en` is 0 or `mmu_present` is 0, the response has `rsp_ok`=1 and `rsp_paddr` equal to the probed `req_vaddr`, whatever the table holds.
- R2: The set searched is `req_vaddr[18:13]` (the virtual page number modulo the set count). An entry stored in any other set never matches.
- R3: An entry matches when its match word has bit 0 (valid) set and its bits [31:19] equal `req_vaddr[31:19]`. The other match-word bits are ignored.
- R4: When several ways of the searched set match, the highest-numbered matching way supplies the result.
- R5: On a match with `super_mode`=1, translate-word bit 6 must be set. With `super_mode`=0, translate-word bit 7 must be set. Otherwise the response has `rsp_ok`=0 and `rsp_paddr`=0.
- R6: On a match that passes R5, `rsp_paddr` is translate-word bits [31:13] followed by `req_vaddr[12:0]`, and `rsp_ok`=1.
- R7: A miss gives `rsp_ok`=0 and `rsp_paddr`=0. A miss or a permission fault leaves every table entry unchanged.
- R8: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid`=1. When `rsp_valid` is 0, `rsp_ok` and `rsp_paddr` are 0.
- R9: When `wr_en`=1, the entry at (`wr_way`, `wr_set`) takes `wr_match` and `wr_xlate` at the clock edge. A probe presented in that same cycle sees the previous contents.
- R10: Reset clears `rsp_valid` and every valid bit, so probes after reset with translation on miss.
- R11: A translated physical address of zero is reported with `rsp_ok`=1, so it is distinct from a failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Probe request strobe |
| req_vaddr | input | ADDR_W | Virtual fetch address to probe |
| xlate_en | input | 1 | Instruction translation enabled |
| super_mode | input | 1 | Processor is in supervisor mode |
| mmu_present | input | 1 | Translation unit is present |
| wr_en | input | 1 | Entry write strobe |
| wr_way | input | WAY_W | Way to write |
| wr_set | input | SET_W | Set to write |
| wr_match | input | ADDR_W | Match word: tag in [31:19], valid in bit 0 |
| wr_xlate | input | ADDR_W | Translate word: page number in [31:13], supervisor exec bit 6, user exec bit 7 |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_ok | output | 1 | Response carries a usable physical address |
| rsp_paddr | output | ADDR_W | Physical address, or zero on failure |

## Verification
The bench builds the block with its defaults: four ways, 64 sets and 8 KB pages. Four ways give room for three or more entries with the same tag in one set, so the highest-way priority can be seen, including falling back to a lower way once the top one is invalidated. Six index bits allow entries whose tags are equal but whose sets differ, which separates index errors from tag errors. A 13-bit offset makes the offset pass-through visible beside a page number of zero.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
  // Bit positions inside the words written through the entry port
  localparam int unsigned MATCH_VALID_BIT = 0;
  localparam int unsigned XLATE_SXE_BIT   = 6;
  localparam int unsigned XLATE_UXE_BIT   = 7;

  // Control bits sampled with each probe
  typedef struct packed {
    logic xlate_en;
    logic super_mode;
    logic present;
  } probe_ctrl_t;
endpackage

// File: rtl/itlb_way_store.sv
// One way of the table: per-set tag, page number and permissions held in
// distributed memory, valid bits in flops so a reset can clear them.
module itlb_way_store #(
  parameter int unsigned SET_W = 6,
  parameter int unsigned TAG_W = 13,
  parameter int unsigned PPN_W = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic             wr_valid,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             wr_sxe,
  input  logic             wr_uxe,
  input  logic [SET_W-1:0] rd_set,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [PPN_W-1:0] rd_ppn,
  output logic             rd_sxe,
  output logic             rd_uxe
);
  localparam int unsigned DEPTH = 1 << SET_W;

  logic [TAG_W-1:0] tag_mem  [DEPTH];
  logic [PPN_W-1:0] ppn_mem  [DEPTH];
  logic [1:0]       perm_mem [DEPTH];
  logic [DEPTH-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_set]  <= wr_tag;
      ppn_mem[wr_set]  <= wr_ppn;
      perm_mem[wr_set] <= {wr_uxe, wr_sxe};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_set] <= wr_valid;
    end
  end

  always_comb begin
    rd_valid = valid_q[rd_set];
    rd_tag   = tag_mem[rd_set];
    rd_ppn   = ppn_mem[rd_set];
    rd_sxe   = perm_mem[rd_set][0];
    rd_uxe   = perm_mem[rd_set][1];
  end

  // R10
  valid_cleared_chk: assert property (@(posedge clk) rst |=> (valid_q == '0));
endmodule

// File: rtl/itlb_way_select.sv
// Picks the highest-numbered hitting way and forwards its translation.
module itlb_way_select #(
  parameter int unsigned NWAYS = 4,
  parameter int unsigned PPN_W = 19
) (
  input  logic [NWAYS-1:0]            hit_vec,
  input  logic [NWAYS-1:0][PPN_W-1:0] ppn_vec,
  input  logic [NWAYS-1:0]            sxe_vec,
  input  logic [NWAYS-1:0]            uxe_vec,
  output logic                        any_hit,
  output logic [NWAYS-1:0]            pick_oh,
  output logic [PPN_W-1:0]            pick_ppn,
  output logic                        pick_sxe,
  output logic                        pick_uxe
);
  always_comb begin
    any_hit  = 1'b0;
    pick_oh  = '0;
    pick_ppn = '0;
    pick_sxe = 1'b0;
    pick_uxe = 1'b0;
    // Ascending scan: a later (higher) way overrides an earlier one
    for (int w = 0; w < int'(NWAYS); w++) begin
      if (hit_vec[w]) begin
        any_hit  = 1'b1;
        pick_oh  = '0;
        pick_oh[w] = 1'b1;
        pick_ppn = ppn_vec[w];
        pick_sxe = sxe_vec[w];
        pick_uxe = uxe_vec[w];
      end
    end
  end
endmodule

// File: rtl/itlb_probe.sv
module itlb_probe #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned PAGE_W  = 13,
  parameter int unsigned SET_W   = 6,
  parameter int unsigned NWAYS   = 4,
  parameter int unsigned WAY_W   = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              xlate_en,
  input  logic              super_mode,
  input  logic              mmu_present,
  input  logic              wr_en,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [ADDR_W-1:0] wr_match,
  input  logic [ADDR_W-1:0] wr_xlate,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic [ADDR_W-1:0] rsp_paddr
);
  import itlb_pkg::*;

  localparam int unsigned TAG_LO = PAGE_W + SET_W;
  localparam int unsigned TAG_W  = ADDR_W - TAG_LO;
  localparam int unsigned PPN_W  = ADDR_W - PAGE_W;

  probe_ctrl_t ctrl;
  assign ctrl = '{xlate_en: xlate_en, super_mode: super_mode, present: mmu_present};

  logic [SET_W-1:0] probe_set;
  logic [TAG_W-1:0] probe_tag;
  assign probe_set = req_vaddr[TAG_LO-1:PAGE_W];
  assign probe_tag = req_vaddr[ADDR_W-1:TAG_LO];

  logic [NWAYS-1:0]            hit_vec;
  logic [NWAYS-1:0][PPN_W-1:0] ppn_vec;
  logic [NWAYS-1:0]            sxe_vec;
  logic [NWAYS-1:0]            uxe_vec;

  for (genvar w = 0; w < int'(NWAYS); w++) begin : g_way
    logic             way_wr;
    logic             rd_valid;
    logic [TAG_W-1:0] rd_tag;

    assign way_wr = wr_en && (wr_way == WAY_W'(w));

    itlb_way_store #(
      .SET_W (SET_W),
      .TAG_W (TAG_W),
      .PPN_W (PPN_W)
    ) store_i (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (way_wr),
      .wr_set   (wr_set),
      .wr_valid (wr_match[MATCH_VALID_BIT]),
      .wr_tag   (wr_match[ADDR_W-1:TAG_LO]),
      .wr_ppn   (wr_xlate[ADDR_W-1:PAGE_W]),
      .wr_sxe   (wr_xlate[XLATE_SXE_BIT]),
      .wr_uxe   (wr_xlate[XLATE_UXE_BIT]),
      .rd_set   (probe_set),
      .rd_valid (rd_valid),
      .rd_tag   (rd_tag),
      .rd_ppn   (ppn_vec[w]),
      .rd_sxe   (sxe_vec[w]),
      .rd_uxe   (uxe_vec[w])
    );

    assign hit_vec[w] = rd_valid && (rd_tag == probe_tag);
  end

  logic              any_hit;
  logic [NWAYS-1:0]  pick_oh;
  logic [PPN_W-1:0]  pick_ppn;
  logic              pick_sxe;
  logic              pick_uxe;

  itlb_way_select #(
    .NWAYS (NWAYS),
    .PPN_W (PPN_W)
  ) select_i (
    .hit_vec  (hit_vec),
    .ppn_vec  (ppn_vec),
    .sxe_vec  (sxe_vec),
    .uxe_vec  (uxe_vec),
    .any_hit  (any_hit),
    .pick_oh  (pick_oh),
    .pick_ppn (pick_ppn),
    .pick_sxe (pick_sxe),
    .pick_uxe (pick_uxe)
  );

  // Result formation
  logic              bypass;
  logic              perm_ok;
  logic              nxt_ok;
  logic [ADDR_W-1:0] nxt_paddr;

  always_comb begin
    bypass  = !ctrl.xlate_en || !ctrl.present;
    perm_ok = ctrl.super_mode ? pick_sxe : pick_uxe;
    if (bypass) begin
      nxt_ok    = 1'b1;
      nxt_paddr = req_vaddr;
    end else if (any_hit && perm_ok) begin
      nxt_ok    = 1'b1;
      nxt_paddr = {pick_ppn, req_vaddr[PAGE_W-1:0]};
    end else begin
      nxt_ok    = 1'b0;
      nxt_paddr = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_ok    <= req_valid && nxt_ok;
      rsp_paddr <= req_valid ? nxt_paddr : '0;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{wr_match[TAG_LO-1:1], wr_xlate[PAGE_W-1:0]};

  // R8
  rsp_follow_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R8
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_ok && rsp_paddr == '0));
  // R1
  bypass_identity_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (!xlate_en || !mmu_present)) |=>
      (rsp_ok && rsp_paddr == $past(req_vaddr)));
  // R7
  fail_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ok) |-> (rsp_paddr == '0));
  // R6
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (!rsp_ok || rsp_paddr[PAGE_W-1:0] == $past(req_vaddr[PAGE_W-1:0])));
  // R4
  single_pick_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pick_oh) && ((pick_oh & ~hit_vec) == '0));
  // R10
  reset_idle_chk: assert property (@(posedge clk) rst |=> !rsp_valid);
endmodule

// File: tb/itlb_probe_tb.sv
`timescale 1ns/100ps
module itlb_probe_tb_top;
  localparam int ADDR_W = 32;
  localparam int SET_W  = 6;
  localparam int WAY_W  = 2;

  logic              clk = 1'b0;
  logic              rst;
  logic              req_valid;
  logic [ADDR_W-1:0] req_vaddr;
  logic              xlate_en, super_mode, mmu_present;
  logic              wr_en;
  logic [WAY_W-1:0]  wr_way;
  logic [SET_W-1:0]  wr_set;
  logic [ADDR_W-1:0] wr_match, wr_xlate;
  logic              rsp_valid, rsp_ok;
  logic [ADDR_W-1:0] rsp_paddr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  itlb_probe dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .xlate_en(xlate_en), .super_mode(super_mode), .mmu_present(mmu_present),
    .wr_en(wr_en), .wr_way(wr_way), .wr_set(wr_set), .wr_match(wr_match),
    .wr_xlate(wr_xlate), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .rsp_paddr(rsp_paddr)
  );

  function automatic logic [31:0] va(input logic [12:0] tag, input logic [5:0] set,
                                     input logic [12:0] off);
    return {tag, set, off};
  endfunction
  // Middle bits filled with noise: they must be ignored (R3)
  function automatic logic [31:0] mw(input logic [12:0] tag, input logic v);
    return {tag, 18'h2A5A4, v};
  endfunction
  function automatic logic [31:0] xw(input logic [18:0] ppn, input logic sx, input logic ux);
    return {ppn, 5'b0, ux, sx, 6'b0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_entry(input int way, input int set, input logic [31:0] m,
                             input logic [31:0] x);
    @(negedge clk);
    wr_en = 1'b1; wr_way = WAY_W'(way); wr_set = SET_W'(set); wr_match = m; wr_xlate = x;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Probe and check ok flag and address one cycle later
  task automatic probe(input string req, input logic [31:0] a, input logic xe,
                       input logic sm, input logic pr, input logic eok,
                       input logic [31:0] epa);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = a; xlate_en = xe; super_mode = sm; mmu_present = pr;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid"}, 32'(rsp_valid), 32'd1);
    check({req, " ok"}, 32'(rsp_ok), 32'(eok));
    check({req, " paddr"}, rsp_paddr, epa);
  endtask

  task automatic t_reset();
    check("R10 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    probe("R10 miss after reset", va(13'h0, 6'd0, 13'h10), 1, 1, 1, 0, 32'h0);
  endtask

  task automatic t_bypass();
    write_entry(0, 9, mw(13'h0F0, 1), xw(19'h7FFFF, 1, 1));
    probe("R1 translation off", va(13'h0F0, 6'd9, 13'h123), 0, 1, 1, 1, va(13'h0F0, 6'd9, 13'h123));
    probe("R1 unit absent", va(13'h0F0, 6'd9, 13'h456), 1, 0, 0, 1, va(13'h0F0, 6'd9, 13'h456));
  endtask

  task automatic t_basic_hit();
    write_entry(0, 3, mw(13'h0AB, 1), xw(19'h12345, 1, 1));
    probe("R6 hit supervisor", va(13'h0AB, 6'd3, 13'h1F0F), 1, 1, 1, 1, {19'h12345, 13'h1F0F});
    probe("R3 hit user", va(13'h0AB, 6'd3, 13'h0001), 1, 0, 1, 1, {19'h12345, 13'h0001});
    probe("R2 other set misses", va(13'h0AB, 6'd4, 13'h0001), 1, 1, 1, 0, 32'h0);
    probe("R3 other tag misses", va(13'h0AC, 6'd3, 13'h0001), 1, 1, 1, 0, 32'h0);
    write_entry(1, 20, mw(13'h0AB, 0), xw(19'h1, 1, 1));
    probe("R3 invalid entry misses", va(13'h0AB, 6'd20, 13'h0), 1, 1, 1, 0, 32'h0);
  endtask

  task automatic t_perm();
    write_entry(1, 7, mw(13'h100, 1), xw(19'h00042, 1, 0));
    probe("R5 supervisor allowed", va(13'h100, 6'd7, 13'h8), 1, 1, 1, 1, {19'h00042, 13'h8});
    probe("R5 user denied", va(13'h100, 6'd7, 13'h8), 1, 0, 1, 0, 32'h0);
    write_entry(2, 8, mw(13'h101, 1), xw(19'h00077, 0, 1));
    probe("R5 user allowed", va(13'h101, 6'd8, 13'hFF), 1, 0, 1, 1, {19'h00077, 13'hFF});
    probe("R5 supervisor denied", va(13'h101, 6'd8, 13'hFF), 1, 1, 1, 0, 32'h0);
  endtask

  task automatic t_priority();
    write_entry(0, 10, mw(13'h055, 1), xw(19'h0AAAA, 1, 1));
    write_entry(3, 10, mw(13'h055, 1), xw(19'h33333, 1, 1));
    write_entry(1, 10, mw(13'h055, 1), xw(19'h11111, 1, 1));
    probe("R4 highest way wins", va(13'h055, 6'd10, 13'h2), 1, 1, 1, 1, {19'h33333, 13'h2});
    write_entry(3, 10, mw(13'h055, 0), xw(19'h33333, 1, 1));
    probe("R4 next highest after invalidate", va(13'h055, 6'd10, 13'h2), 1, 1, 1, 1, {19'h11111, 13'h2});
  endtask

  task automatic t_zero_pa();
    write_entry(0, 0, mw(13'h000, 1), xw(19'h0, 1, 0));
    probe("R11 zero physical address", va(13'h0, 6'd0, 13'h0), 1, 1, 1, 1, 32'h0);
  endtask

  task automatic t_write_same_cycle();
    write_entry(2, 12, mw(13'h077, 1), xw(19'h0A0A0, 1, 1));
    @(negedge clk);
    wr_en = 1'b1; wr_way = 2'd2; wr_set = 6'd12; wr_match = mw(13'h077, 1);
    wr_xlate = xw(19'h0B0B0, 1, 1);
    req_valid = 1'b1; req_vaddr = va(13'h077, 6'd12, 13'h5);
    xlate_en = 1'b1; super_mode = 1'b1; mmu_present = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    check("R9 same-cycle probe sees old", rsp_paddr, {19'h0A0A0, 13'h5});
    probe("R9 later probe sees new", va(13'h077, 6'd12, 13'h5), 1, 1, 1, 1, {19'h0B0B0, 13'h5});
  endtask

  task automatic t_no_side_effect();
    probe("R7 miss", va(13'h1FFF, 6'd3, 13'h0), 1, 1, 1, 0, 32'h0);
    probe("R7 fault", va(13'h100, 6'd7, 13'h0), 1, 0, 1, 0, 32'h0);
    probe("R7 entry intact after miss", va(13'h0AB, 6'd3, 13'h3), 1, 1, 1, 1, {19'h12345, 13'h3});
    probe("R7 entry intact after fault", va(13'h100, 6'd7, 13'h9), 1, 1, 1, 1, {19'h00042, 13'h9});
  endtask

  task automatic t_latency();
    probe("R8 strobe", va(13'h0AB, 6'd3, 13'h3), 1, 1, 1, 1, {19'h12345, 13'h3});
    @(negedge clk);
    check("R8 strobe drops", 32'(rsp_valid), 32'd0);
    check("R8 idle paddr zero", rsp_paddr, 32'h0);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; xlate_en = 1'b0; super_mode = 1'b0;
    mmu_present = 1'b0; wr_en = 1'b0; wr_way = '0; wr_set = '0; wr_match = '0; wr_xlate = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_basic_hit();
    t_perm();
    t_priority();
    t_zero_pa();
    t_write_same_cycle();
    t_no_side_effect();
    t_latency();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule